// File: doc/BRIEF.md
# Static Conditional-Branch Predictor with Stall Accounting

This block sits beside the decode stage of a pipelined core. For each conditional branch it receives the length of the encoding and the signed branch displacement. In the same cycle it returns a taken or not-taken guess, using only those two fields. The guess of the most recently decoded branch is held in the block.

When the branch later resolves, the core presents the real outcome. The block compares it with the held guess and reports a fixed cycle cost for that guess/outcome pair. It raises a one-cycle mispredict flag when the two disagree. It also adds the cost to a saturating running total, which a synchronous clear resets. The cost output lets the core or a performance model insert the matching number of fetch bubbles. The total gives timing statistics for a stretch of code.

Top module: `brp_static`

## Requirements
- R1: While the displacement `dec_disp_i` (two's complement) is negative, `pred_taken_o` is 1 in the same cycle, for either encoding length.
- R2: A displacement of exactly zero is treated as a backward branch: `pred_taken_o` is 1 in the same cycle.
- R3: A positive displacement with `dec_short_i`=1 (16-bit encoding) gives `pred_taken_o`=1.
- R4: A positive displacement with `dec_short_i`=0 (32-bit encoding) gives `pred_taken_o`=0.
- R5: One cycle after `res_valid_i`, `pen_valid_o` is 1 and `pen_cycles_o` carries the cost of the held guess against `res_taken_i`. The costs are: guessed taken and taken, 2; guessed taken and not taken, 3; guessed not taken and taken, 3; guessed not taken and not taken, 1. One cycle after a cycle without `res_valid_i`, both outputs are 0.
- R6: `mispred_o` is 1 for exactly the one cycle after a resolution whose outcome differs from the held guess. At all other times it is 0.
- R7: A resolution is judged against the guess of the last `dec_valid_i` cycle strictly before it. A decode in the same cycle as a resolution affects only later resolutions.
- R8: Each resolution adds its cost to `stall_total_o`, visible one cycle later. The total sticks at its all-ones maximum instead of wrapping.
- R9: `clr_i` makes `stall_total_o` 0 one cycle later. It takes priority over a resolution in the same cycle, whose cost is then not added.
- R10: After reset, `stall_total_o`=0, `pen_valid_o`=0, `mispred_o`=0, and the held guess is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_valid_i | input | 1 | A conditional branch is in decode; its guess is stored |
| dec_short_i | input | 1 | 1: 16-bit encoding, 0: 32-bit encoding |
| dec_disp_i | input | DISP_W | Signed branch displacement |
| pred_taken_o | output | 1 | Same-cycle guess for the decode inputs |
| res_valid_i | input | 1 | The outstanding branch resolves this cycle |
| res_taken_i | input | 1 | Actual outcome of the resolving branch |
| clr_i | input | 1 | Synchronous clear of the running total |
| pen_valid_o | output | 1 | A cost is reported this cycle |
| pen_cycles_o | output | PEN_W | Cost in cycles of the last resolution |
| mispred_o | output | 1 | Last resolution disagreed with its guess |
| stall_total_o | output | CNT_W | Saturating sum of reported costs |

## Verification
Two pairs of events can fall in the same cycle. A new decode can coincide with the resolution of the previous branch, and a clear can coincide with a resolution. The bench provokes both. It decodes a branch guessed taken, then resolves it in the very cycle a branch guessed not taken is decoded. It expects the cost of the older guess, then the cost of the newer guess at the following resolution. It also raises the clear together with a resolution and expects a zero total. Beyond these, the bench sweeps every displacement of a narrow configuration under both encoding lengths and both outcomes. It compares each cost and the saturating total with values computed arithmetically.

// File: rtl/brp_pkg.sv
package brp_pkg;
  typedef enum logic [1:0] {
    CMB_NN = 2'b00,
    CMB_NT = 2'b01,
    CMB_TN = 2'b10,
    CMB_TT = 2'b11
  } brp_combo_e;

  function automatic brp_combo_e brp_combo(input logic guess, input logic actual);
    return brp_combo_e'({guess, actual});
  endfunction
endpackage

// File: rtl/brp_dir.sv
module brp_dir #(
  parameter int DISP_W = 16
) (
  input  logic              short_i,
  input  logic [DISP_W-1:0] disp_i,
  output logic              taken_o
);
  logic backward;

  always_comb begin
    backward = disp_i[DISP_W-1] | (disp_i == '0);
    taken_o  = backward | short_i;
  end
endmodule

// File: rtl/brp_cost.sv
module brp_cost
  import brp_pkg::*;
#(
  parameter int PEN_W  = 2,
  parameter int PEN_NN = 1,
  parameter int PEN_NT = 3,
  parameter int PEN_TN = 3,
  parameter int PEN_TT = 2
) (
  input  logic             guess_i,
  input  logic             actual_i,
  output logic [PEN_W-1:0] cost_o,
  output logic             miss_o
);
  brp_combo_e combo;

  always_comb begin
    combo  = brp_combo(guess_i, actual_i);
    miss_o = guess_i ^ actual_i;
    unique case (combo)
      CMB_NN:  cost_o = PEN_W'(PEN_NN);
      CMB_NT:  cost_o = PEN_W'(PEN_NT);
      CMB_TN:  cost_o = PEN_W'(PEN_TN);
      default: cost_o = PEN_W'(PEN_TT);
    endcase
  end
endmodule

// File: rtl/brp_accum.sv
module brp_accum #(
  parameter int CNT_W = 32,
  parameter int PEN_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             add_i,
  input  logic [PEN_W-1:0] amount_i,
  output logic [CNT_W-1:0] total_o
);
  localparam int SUM_W = CNT_W + 1;

  logic [CNT_W-1:0] total_q, total_d;
  logic [SUM_W-1:0] sum;
  logic             total_en;

  always_comb begin
    sum      = SUM_W'(total_q) + SUM_W'(amount_i);
    total_en = clr_i | add_i;
    if (clr_i)
      total_d = '0;
    else if (sum[CNT_W])
      total_d = '1;
    else
      total_d = sum[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      total_q <= '0;
    else if (total_en)
      total_q <= total_d;
  end

  assign total_o = total_q;
endmodule

// File: rtl/brp_static.sv
module brp_static #(
  parameter int DISP_W = 16,
  parameter int CNT_W  = 32,
  parameter int PEN_W  = 2,
  parameter int PEN_NN = 1,
  parameter int PEN_NT = 3,
  parameter int PEN_TN = 3,
  parameter int PEN_TT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dec_valid_i,
  input  logic              dec_short_i,
  input  logic [DISP_W-1:0] dec_disp_i,
  output logic              pred_taken_o,
  input  logic              res_valid_i,
  input  logic              res_taken_i,
  input  logic              clr_i,
  output logic              pen_valid_o,
  output logic [PEN_W-1:0]  pen_cycles_o,
  output logic              mispred_o,
  output logic [CNT_W-1:0]  stall_total_o
);
  logic             guess_now;
  logic             held_q;
  logic [PEN_W-1:0] cost;
  logic             miss;
  logic             pen_valid_q, pen_valid_d;
  logic [PEN_W-1:0] pen_cycles_q, pen_cycles_d;
  logic             mispred_q, mispred_d;

  brp_dir #(.DISP_W(DISP_W)) u_dir (
    .short_i (dec_short_i),
    .disp_i  (dec_disp_i),
    .taken_o (guess_now)
  );

  brp_cost #(
    .PEN_W(PEN_W), .PEN_NN(PEN_NN), .PEN_NT(PEN_NT),
    .PEN_TN(PEN_TN), .PEN_TT(PEN_TT)
  ) u_cost (
    .guess_i  (held_q),
    .actual_i (res_taken_i),
    .cost_o   (cost),
    .miss_o   (miss)
  );

  brp_accum #(.CNT_W(CNT_W), .PEN_W(PEN_W)) u_accum (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_i    (clr_i),
    .add_i    (res_valid_i),
    .amount_i (cost),
    .total_o  (stall_total_o)
  );

  always_comb begin
    pen_valid_d  = res_valid_i;
    pen_cycles_d = res_valid_i ? cost : '0;
    mispred_d    = res_valid_i & miss;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      held_q <= 1'b0;
    else if (dec_valid_i)
      held_q <= guess_now;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pen_valid_q  <= 1'b0;
      pen_cycles_q <= '0;
      mispred_q    <= 1'b0;
    end else begin
      pen_valid_q  <= pen_valid_d;
      pen_cycles_q <= pen_cycles_d;
      mispred_q    <= mispred_d;
    end
  end

  assign pred_taken_o = guess_now;
  assign pen_valid_o  = pen_valid_q;
  assign pen_cycles_o = pen_cycles_q;
  assign mispred_o    = mispred_q;
endmodule

// File: rtl/brp_static_chk.sv
module brp_static_chk #(
  parameter int DISP_W = 16,
  parameter int CNT_W  = 32,
  parameter int PEN_W  = 2,
  parameter int PEN_NT = 3,
  parameter int PEN_TN = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dec_short_i,
  input logic [DISP_W-1:0] dec_disp_i,
  input logic              pred_taken_o,
  input logic              res_valid_i,
  input logic              clr_i,
  input logic              pen_valid_o,
  input logic [PEN_W-1:0]  pen_cycles_o,
  input logic              mispred_o,
  input logic [CNT_W-1:0]  stall_total_o
);
  // R1: negative displacement is guessed taken
  p_back_taken_r1: assert property (@(posedge clk) disable iff (!rst_n)
    dec_disp_i[DISP_W-1] |-> pred_taken_o);

  // R4: positive displacement with long encoding is guessed not taken
  p_long_fwd_nt_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!dec_short_i && !dec_disp_i[DISP_W-1] && dec_disp_i != '0) |-> !pred_taken_o);

  // R5: a cost is reported exactly one cycle after each resolution
  p_pen_after_res_r5: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid_i |=> pen_valid_o);

  p_no_pen_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid_i |=> (!pen_valid_o && pen_cycles_o == '0));

  // R6: mispredict only accompanies a reported mismatch cost
  p_miss_cost_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mispred_o |-> (pen_valid_o && (pen_cycles_o == PEN_W'(PEN_NT) ||
                                   pen_cycles_o == PEN_W'(PEN_TN))));

  // R8: the total never falls without a clear and sticks at its maximum
  p_total_mono_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> (stall_total_o >= $past(stall_total_o)));

  p_total_sat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_total_o == '1 && !clr_i) |=> (stall_total_o == '1));

  // R9: clear empties the total on the next cycle
  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (stall_total_o == '0));

  // R9: without a clear or resolution the total holds
  p_total_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !res_valid_i) |=> $stable(stall_total_o));
endmodule

bind brp_static brp_static_chk #(
  .DISP_W(DISP_W), .CNT_W(CNT_W), .PEN_W(PEN_W),
  .PEN_NT(PEN_NT), .PEN_TN(PEN_TN)
) u_brp_static_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .dec_short_i   (dec_short_i),
  .dec_disp_i    (dec_disp_i),
  .pred_taken_o  (pred_taken_o),
  .res_valid_i   (res_valid_i),
  .clr_i         (clr_i),
  .pen_valid_o   (pen_valid_o),
  .pen_cycles_o  (pen_cycles_o),
  .mispred_o     (mispred_o),
  .stall_total_o (stall_total_o)
);

// File: tb/test_brp_static.sv
module test_brp_static;
  localparam int DISP_W = 6;
  localparam int CNT_W  = 5;
  localparam int PEN_W  = 2;
  localparam int TMAX   = (1 << CNT_W) - 1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              dec_valid_i = 1'b0;
  logic              dec_short_i = 1'b0;
  logic [DISP_W-1:0] dec_disp_i = '0;
  logic              pred_taken_o;
  logic              res_valid_i = 1'b0;
  logic              res_taken_i = 1'b0;
  logic              clr_i = 1'b0;
  logic              pen_valid_o;
  logic [PEN_W-1:0]  pen_cycles_o;
  logic              mispred_o;
  logic [CNT_W-1:0]  stall_total_o;

  int total = 0;
  int bad   = 0;
  int model = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  brp_static #(.DISP_W(DISP_W), .CNT_W(CNT_W), .PEN_W(PEN_W)) i_brp_static (
    .clk(clk), .rst_n(rst_n),
    .dec_valid_i(dec_valid_i), .dec_short_i(dec_short_i), .dec_disp_i(dec_disp_i),
    .pred_taken_o(pred_taken_o),
    .res_valid_i(res_valid_i), .res_taken_i(res_taken_i), .clr_i(clr_i),
    .pen_valid_o(pen_valid_o), .pen_cycles_o(pen_cycles_o),
    .mispred_o(mispred_o), .stall_total_o(stall_total_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int cost(input bit guess, input bit actual);
    if (guess != actual) return 3;
    return actual ? 2 : 1;
  endfunction

  function automatic int sat_add(input int t, input int p);
    return (t + p > TMAX) ? TMAX : t + p;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // resolve outstanding branch with outcome act; optional same-cycle decode
  task automatic resolve(input bit act, input bit guess, input string tag);
    int p;
    @(negedge clk);
    res_valid_i = 1'b1; res_taken_i = act;
    @(negedge clk);
    res_valid_i = 1'b0; dec_valid_i = 1'b0;
    p = cost(guess, act);
    model = sat_add(model, p);
    chk({tag, " R5 pen_valid"}, int'(pen_valid_o), 1);
    chk({tag, " R5 pen_cycles"}, int'(pen_cycles_o), p);
    chk({tag, " R6 mispred"}, int'(mispred_o), int'(guess != act));
    chk({tag, " R8 total"}, int'(stall_total_o), model);
  endtask

  initial begin
    #(4 * 150000);
    total++; bad++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    int n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 total", int'(stall_total_o), 0);
    chk("R10 pen_valid", int'(pen_valid_o), 0);
    chk("R10 mispred", int'(mispred_o), 0);
    // R10: held guess is not taken after reset
    resolve(1'b1, 1'b0, "R10 held");

    // sweep both lengths, every displacement, both outcomes
    for (int s = 0; s < 2; s++) begin
      for (int d = -(1 << (DISP_W-1)); d < (1 << (DISP_W-1)); d++) begin
        for (int a = 0; a < 2; a++) begin
          bit exp_t;
          string tag;
          if (n % 9 == 0) begin
            @(negedge clk);
            clr_i = 1'b1;
            @(negedge clk);
            clr_i = 1'b0;
            model = 0;
            chk("R9 clear", int'(stall_total_o), 0);
          end
          n++;
          exp_t = (d <= 0) || (s == 1);
          if (d < 0) tag = "R1";
          else if (d == 0) tag = "R2";
          else if (s == 1) tag = "R3";
          else tag = "R4";
          @(negedge clk);
          dec_valid_i = 1'b1; dec_short_i = s[0]; dec_disp_i = d[DISP_W-1:0];
          #1;
          chk({tag, " guess"}, int'(pred_taken_o), int'(exp_t));
          @(negedge clk);
          dec_valid_i = 1'b0;
          resolve(a[0], exp_t, tag);
        end
      end
    end

    // idle cycle: no report (R5, R6)
    @(negedge clk);
    @(negedge clk);
    chk("R5 idle pen_valid", int'(pen_valid_o), 0);
    chk("R5 idle pen_cycles", int'(pen_cycles_o), 0);
    chk("R6 idle mispred", int'(mispred_o), 0);

    // R7: decode in same cycle as resolution
    @(negedge clk);
    clr_i = 1'b1;
    @(negedge clk);
    clr_i = 1'b0; model = 0;
    dec_valid_i = 1'b1; dec_short_i = 1'b1; dec_disp_i = 6'd5;   // guessed taken
    @(negedge clk);
    dec_valid_i = 1'b1; dec_short_i = 1'b0; dec_disp_i = 6'd9;   // guessed not taken
    res_valid_i = 1'b1; res_taken_i = 1'b0;                      // resolves older one
    @(negedge clk);
    res_valid_i = 1'b0; dec_valid_i = 1'b0;
    model = sat_add(model, 3);
    chk("R7 older cost", int'(pen_cycles_o), 3);
    chk("R7 older mispred", int'(mispred_o), 1);
    resolve(1'b0, 1'b0, "R7 newer");

    // R9: clear wins over same-cycle resolution
    @(negedge clk);
    res_valid_i = 1'b1; res_taken_i = 1'b1; clr_i = 1'b1;
    @(negedge clk);
    res_valid_i = 1'b0; clr_i = 1'b0; model = 0;
    chk("R9 clear priority", int'(stall_total_o), 0);

    // R8: saturation with repeated mismatches
    for (int k = 0; k < 14; k++) resolve(1'b1, 1'b0, "R8 sat");
    chk("R8 stuck at max", int'(stall_total_o), TMAX);

    finish_run();
  end
endmodule